// File: doc/BRIEF.md
# Paged Instruction Address Unit with Return Stack

This block holds the instruction address of a small processor and the stack of return addresses used by subroutine calls. The 15-bit address has two parts: a 2-bit page selector in the top bits and a 13-bit offset inside the page. This gives four pages of 8192 locations each. Stepping to the next instruction advances only the offset. Execution therefore wraps around inside the current page and never moves into the next page by itself. Only a jump, a call or a return can change the page.

Calls and returns use an eight-entry stack of 15-bit return addresses held inside the block. A 3-bit pointer addresses the stack, and that pointer is the field the processor keeps in its upper status word. A call saves the address of the instruction that follows the current one. It then moves to the target, all in one cycle. A return restores the saved address in one cycle. When calls nest more than eight deep, the pointer wraps and the oldest saved address is overwritten without any indication.

The processor's sequencer drives the control strobes: reset, return, call, jump and step. Memory access, instruction decoding and indirect-address resolution are outside this block.

Top module: `paged_pc`

## Requirements
- R1: While `rst` is high at a clock edge, `addr` becomes 0, `sp` becomes 0 and every stack entry is cleared to 0. This takes precedence over all other controls.
- R2: A step (`inc`) sets `addr[12:0]` to `addr[12:0]+1` modulo 8192 and leaves the page bits `addr[14:13]` unchanged. For example, 0x1FFF steps to 0x0000 and 0x7FFF steps to 0x6000.
- R3: A jump (`jump`) loads all 15 bits of `target` into `addr`, so it can move to any page. `sp` is unchanged.
- R4: A call (`call`) increments `sp` by 1 modulo 8 and writes the next-instruction address into the stack entry at the new `sp`. The next-instruction address is formed by the same in-page wrap as R2. In the same cycle, `addr` is loaded with `target`.
- R5: A return (`ret`) loads `addr` from the stack entry at the current `sp`. After the read, `sp` is decremented by 1 modulo 8.
- R6: The pointer wraps both ways. A ninth nested call overwrites the entry saved by the first call. A return taken at `sp`=0 reads entry 0 and leaves `sp`=7.
- R7: When several controls are active together, only the highest-priority one takes effect. The order is reset, then return, then call, then jump, then step.
- R8: With no control active, `addr` and `sp` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inc | input | 1 | Advance to the next instruction inside the page |
| jump | input | 1 | Load `target` into the address |
| call | input | 1 | Push the return address and load `target` |
| ret | input | 1 | Pop the return address into the address |
| target | input | 15 | Destination address for a jump or call |
| addr | output | 15 | Current instruction address |
| sp | output | 3 | Return-stack pointer |

## Verification
Steps are applied at an ordinary offset and at the last offset of page 0 and page 3. This separates an in-page wrap from a carry into the page bits. Calls are made from in-page positions and from offset 0x1FFF of page 2. The second case exposes a return address that is not wrapped inside its page. Nested call/return chains check the last-in-first-out order, and a nine-deep chain followed by returns shows where the pointer overwrites the oldest entry. Combined strobes with different targets show which control wins, and a return straight after reset shows the pointer wrapping downward.

// File: rtl/paged_pc.sv
module paged_pc #(
  parameter int PAGE_W = 2,
  parameter int OFF_W  = 13,
  parameter int DEPTH  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      inc,
  input  logic                      jump,
  input  logic                      call,
  input  logic                      ret,
  input  logic [PAGE_W+OFF_W-1:0]   target,
  output logic [PAGE_W+OFF_W-1:0]   addr,
  output logic [$clog2(DEPTH)-1:0]  sp
);
  localparam int AW  = PAGE_W + OFF_W;
  localparam int SPW = $clog2(DEPTH);

  logic [AW-1:0] stack [DEPTH];

  wire [AW-1:0]  next_seq = {addr[AW-1:OFF_W], addr[OFF_W-1:0] + 1'b1};
  wire [SPW-1:0] sp_up    = sp + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      sp   <= '0;
      for (int i = 0; i < DEPTH; i++) stack[i] <= '0;
    end else if (ret) begin
      addr <= stack[sp];
      sp   <= sp - 1'b1;
    end else if (call) begin
      stack[sp_up] <= next_seq;
      addr         <= target;
      sp           <= sp_up;
    end else if (jump) begin
      addr <= target;
    end else if (inc) begin
      addr <= next_seq;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (addr == '0 && sp == '0));

  // R2
  step_in_page_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !jump && !call && !ret) |=>
      (addr[AW-1:OFF_W] == $past(addr[AW-1:OFF_W]) &&
       addr[OFF_W-1:0] == OFF_W'($past(addr[OFF_W-1:0]) + 1'b1)));

  // R3
  jump_load_chk: assert property (@(posedge clk) disable iff (rst)
    (jump && !call && !ret) |=> (addr == $past(target) && $stable(sp)));

  // R4
  call_push_chk: assert property (@(posedge clk) disable iff (rst)
    (call && !ret) |=> (addr == $past(target) && sp == SPW'($past(sp) + 1'b1)));

  // R5 R7
  ret_pop_chk: assert property (@(posedge clk) disable iff (rst)
    ret |=> (sp == SPW'($past(sp) - 1'b1)));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!inc && !jump && !call && !ret) |=> ($stable(addr) && $stable(sp)));
endmodule

// File: tb/tb_paged_pc.sv
module tb_paged_pc;
  logic        clk = 1'b0;
  logic        rst, inc, jump, call, ret;
  logic [14:0] target;
  logic [14:0] addr;
  logic [2:0]  sp;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  paged_pc dut (.clk(clk), .rst(rst), .inc(inc), .jump(jump), .call(call),
                .ret(ret), .target(target), .addr(addr), .sp(sp));

  // {rst,inc,jump,call,ret, target, expected addr, expected sp}
  localparam logic [37:0] VEC [20] = '{
    {5'b10000, 15'h0000, 15'h0000, 3'd0},  // R1
    {5'b01000, 15'h0000, 15'h0001, 3'd0},  // R2
    {5'b01000, 15'h0000, 15'h0002, 3'd0},  // R2
    {5'b00100, 15'h1FFF, 15'h1FFF, 3'd0},  // R3
    {5'b01000, 15'h0000, 15'h0000, 3'd0},  // R2 wrap page 0
    {5'b00100, 15'h7FFF, 15'h7FFF, 3'd0},  // R3
    {5'b01000, 15'h0000, 15'h6000, 3'd0},  // R2 wrap page 3
    {5'b00100, 15'h2005, 15'h2005, 3'd0},  // R3
    {5'b00010, 15'h4100, 15'h4100, 3'd1},  // R4 push 2006
    {5'b01000, 15'h0000, 15'h4101, 3'd1},  // R2
    {5'b00010, 15'h5FFF, 15'h5FFF, 3'd2},  // R4 push 4102
    {5'b00010, 15'h0010, 15'h0010, 3'd3},  // R4 push 4000 (in-page wrap)
    {5'b00001, 15'h0000, 15'h4000, 3'd2},  // R5
    {5'b00001, 15'h0000, 15'h4102, 3'd1},  // R5
    {5'b00001, 15'h0000, 15'h2006, 3'd0},  // R5
    {5'b01110, 15'h3000, 15'h3000, 3'd1},  // R7 call wins, push 2007
    {5'b01011, 15'h0555, 15'h2007, 3'd0},  // R7 ret wins
    {5'b01100, 15'h0AAA, 15'h0AAA, 3'd0},  // R7 jump over step
    {5'b00000, 15'h1111, 15'h0AAA, 3'd0},  // R8
    {5'b10011, 15'h1234, 15'h0000, 3'd0}   // R1 R7 reset wins
  };

  task automatic drive(input logic [4:0] c, input logic [14:0] t);
    @(negedge clk);
    {rst, inc, jump, call, ret} = c;
    target = t;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [14:0] ea, input logic [2:0] es);
    checks++;
    if (addr !== ea || sp !== es) begin
      errors++;
      $display("FAIL %s: addr=%h sp=%0d expected addr=%h sp=%0d", req, addr, sp, ea, es);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected below 5000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    {rst, inc, jump, call, ret} = 5'b10000;
    target = '0;
    for (int i = 0; i < 20; i++) begin
      drive(VEC[i][37:33], VEC[i][32:18]);
      check($sformatf("vector %0d (R1..R8 table)", i), VEC[i][17:3], VEC[i][2:0]);
    end

    // R6: return right after reset wraps pointer to 7, reads cleared entry 0
    drive(5'b10000, 15'h0);
    drive(5'b00001, 15'h0);
    check("R6 pop at sp0", 15'h0000, 3'd7);

    // R6: nine nested calls overwrite entry 1
    drive(5'b10000, 15'h0);
    for (int k = 1; k <= 9; k++) begin
      drive(5'b00010, 15'(k * 16));
      check("R4 nested call", 15'(k * 16), 3'(k));
    end
    drive(5'b00001, 15'h0);
    check("R6 ninth call overwrote oldest", 15'h0081, 3'd0);
    drive(5'b00001, 15'h0);
    check("R6 pop entry 0", 15'h0071, 3'd7);
    drive(5'b00001, 15'h0);
    check("R6 pop entry 7", 15'h0061, 3'd6);

    drive(5'b00000, 15'h7777);
    check("R8 idle hold", 15'h0061, 3'd6);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule